// File: doc/BRIEF.md
# Byte-Addressed Access Unit over a Word RAM

This unit sits in front of a small RAM organised as whole 32-bit words and lets a processor reach it with byte addresses. The word index is the byte address shifted right by two, so all four byte addresses inside one word reach the same entry. Loads return a byte, a halfword or a full word. Narrow results are widened to 32 bits with either sign extension or zero extension.

The RAM has no per-byte write enables. A byte or halfword store is therefore carried out as a two-step sequence. The unit first captures the containing word, then writes back a merged copy in which only the addressed lane or lanes hold new data. Misaligned accesses and the unused size code end with an error flag and leave the RAM untouched.

A request is taken only when the unit is idle. At acceptance the unit registers every request field, so the requester may change its inputs while a sequence is running. The controller has six states:

- IDLE: waits for a request.
- LOAD: returns read data.
- WSTORE: writes a full word.
- RMW_RD: captures the old word.
- RMW_WR: writes the merged word.
- FAULT: reports an error.

From IDLE, a request moves the unit to FAULT if it is misaligned, to LOAD if it is a read, to WSTORE if it is a word write, and to RMW_RD otherwise. RMW_RD always moves on to RMW_WR. LOAD, WSTORE, RMW_WR and FAULT all return to IDLE.

Top module: `byte_mem_wrap`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_done`, `rsp_err` and `rsp_rdata` are all 0.
- R2: The word entry used is `req_addr[6:2]`, so the four byte addresses of one word reach the same stored word.
- R3: A byte load (size code 2'b00) returns lane `req_addr[1:0]`, with lane n being bits 8n+7:8n (offset 0 is bits 7:0). The lane is sign-extended when `req_signed` is 1 and zero-extended when it is 0.
- R4: A halfword load (size code 2'b01) returns bits 15:0 when `req_addr[1]` is 0 and bits 31:16 when it is 1. It uses the same extension rule as R3.
- R5: A word access (size code 2'b10) loads and stores all 32 bits unchanged, with no extension.
- R6: A byte store replaces only the addressed 8-bit lane of the stored word, taking its new value from `req_wdata[7:0]`.
- R7: A halfword store replaces only the addressed 16-bit half, taking its new value from `req_wdata[15:0]`.
- R8: The following requests complete with `rsp_err`=1 and `rsp_rdata`=0, and leave the RAM unchanged:
  - a halfword with `req_addr[0]`=1;
  - a word with `req_addr[1:0]`≠0;
  - size code 2'b11.
- R9: For loads, word stores and faulting requests, `rsp_done` is high in the cycle after acceptance. For byte and halfword stores it is high in the second cycle after acceptance.
- R10: `req_ready` is 1 only in IDLE. A request presented while busy is ignored. Request fields changed after acceptance have no effect on the access in progress.
- R11: `rsp_done` lasts exactly one cycle, and `rsp_rdata` is 0 in every cycle that is not the completion of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle if valid |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | 7 | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_rdata | output | 32 | Load result, valid with `rsp_done` |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Access rejected, valid with `rsp_done` |

## Verification
Two events can fall in the same cycle: the second step of a narrow-store sequence, and a new request arriving with different address, size and data. The bench provokes this by keeping `req_valid` high through the whole sequence while it changes every request field. It then reads back both the original word and the word named by the late address. The original word must hold the first store's lane merged in, the other word must be untouched, and `req_ready` must stay low until `rsp_done` has dropped.

// File: rtl/bmw_pkg.sv
package bmw_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WSTORE,
        ST_RMW_RD,
        ST_RMW_WR,
        ST_FAULT
    } state_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/bmw_word_array.sv
module bmw_word_array #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[idx_i];

endmodule

// File: rtl/bmw_lane_extract.sv
module bmw_lane_extract
    import bmw_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_i,
    input  logic [1:0]       off_i,
    input  size_e            size_i,
    input  logic             sgn_i,
    output logic [WIDTH-1:0] data_o
);

    localparam int HALF_W = 2 * LANE_W;

    logic [LANE_W-1:0] byte_v;
    logic [HALF_W-1:0] half_v;

    always_comb begin
        byte_v = word_i[LANE_W*off_i +: LANE_W];
        half_v = off_i[1] ? word_i[2*HALF_W-1:HALF_W] : word_i[HALF_W-1:0];
        unique case (size_i)
            SZ_BYTE: data_o = {{(WIDTH-LANE_W){sgn_i & byte_v[LANE_W-1]}}, byte_v};
            SZ_HALF: data_o = {{(WIDTH-HALF_W){sgn_i & half_v[HALF_W-1]}}, half_v};
            default: data_o = word_i;
        endcase
    end

endmodule

// File: rtl/bmw_lane_merge.sv
module bmw_lane_merge
    import bmw_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int LANES = WIDTH / LANE_W
) (
    input  logic [WIDTH-1:0] old_i,
    input  logic [WIDTH-1:0] new_i,
    input  logic [1:0]       off_i,
    input  size_e            size_i,
    output logic [WIDTH-1:0] merged_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [1:0] LANE_ID = 2'(g);
        logic              hit;
        logic [LANE_W-1:0] src;

        assign hit = (size_i == SZ_BYTE) ? (off_i == LANE_ID) :
                     (size_i == SZ_HALF) ? (off_i[1] == LANE_ID[1]) : 1'b1;
        assign src = (size_i == SZ_BYTE) ? new_i[LANE_W-1:0] :
                     (size_i == SZ_HALF) ? new_i[LANE_W*(g%2) +: LANE_W] :
                                           new_i[LANE_W*g +: LANE_W];
        assign merged_o[LANE_W*g +: LANE_W] = hit ? src : old_i[LANE_W*g +: LANE_W];
    end

endmodule

// File: rtl/byte_mem_wrap.sv
module byte_mem_wrap
    import bmw_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [WIDTH-1:0]  req_wdata,
    output logic [WIDTH-1:0]  rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_err
);

    state_e            state_q, state_d;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    size_e             size_q;
    logic              sgn_q;
    logic [WIDTH-1:0]  wdata_q;
    logic [WIDTH-1:0]  old_q;

    logic              accept;
    logic              misaligned;
    size_e             size_in;
    logic              mem_we;
    logic [WIDTH-1:0]  mem_wdata;
    logic [WIDTH-1:0]  mem_rdata;
    logic [WIDTH-1:0]  load_val;
    logic [WIDTH-1:0]  merged;

    assign size_in = size_e'(req_size);
    assign accept  = req_valid && (state_q == ST_IDLE);

    always_comb begin
        unique case (size_in)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = req_addr[0];
            SZ_WORD: misaligned = |req_addr[1:0];
            default: misaligned = 1'b1;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            write_q <= 1'b0;
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            sgn_q   <= 1'b0;
            wdata_q <= '0;
            old_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                write_q <= req_write;
                addr_q  <= req_addr;
                size_q  <= size_in;
                sgn_q   <= req_signed;
                wdata_q <= req_wdata;
            end
            if (state_q == ST_RMW_RD) begin
                old_q <= mem_rdata;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (misaligned)             state_d = ST_FAULT;
                    else if (!req_write)        state_d = ST_LOAD;
                    else if (size_in == SZ_WORD) state_d = ST_WSTORE;
                    else                        state_d = ST_RMW_RD;
                end
            end
            ST_RMW_RD: state_d = ST_RMW_WR;
            ST_LOAD,
            ST_WSTORE,
            ST_RMW_WR,
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_done  = (state_q == ST_LOAD) || (state_q == ST_WSTORE) ||
                    (state_q == ST_RMW_WR) || (state_q == ST_FAULT);
        rsp_err   = (state_q == ST_FAULT);
        rsp_rdata = (state_q == ST_LOAD && !write_q) ? load_val : '0;
        mem_we    = (state_q == ST_WSTORE) || (state_q == ST_RMW_WR);
        mem_wdata = (state_q == ST_WSTORE) ? wdata_q : merged;
    end

    bmw_word_array #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) u_array (
        .clk     (clk),
        .we_i    (mem_we),
        .idx_i   (addr_q[ADDR_W-1:2]),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );

    bmw_lane_extract #(
        .WIDTH (WIDTH)
    ) u_extract (
        .word_i (mem_rdata),
        .off_i  (addr_q[1:0]),
        .size_i (size_q),
        .sgn_i  (sgn_q),
        .data_o (load_val)
    );

    bmw_lane_merge #(
        .WIDTH (WIDTH)
    ) u_merge (
        .old_i    (old_q),
        .new_i    (wdata_q),
        .off_i    (addr_q[1:0]),
        .size_i   (size_q),
        .merged_o (merged)
    );

endmodule

// File: rtl/bmw_checker.sv
module bmw_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [WIDTH-1:0] rsp_rdata,
    input logic             rsp_done,
    input logic             rsp_err
);

    AST_LOAD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_done); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R11

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready); // R10

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_done && rsp_rdata == '0)); // R8

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> (rsp_rdata == '0)); // R11

endmodule

bind byte_mem_wrap bmw_checker #(.WIDTH(WIDTH)) u_bmw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_rdata (rsp_rdata),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err)
);

// File: tb/tb_byte_mem_wrap.sv
`timescale 1ns/1ps
module tb_byte_mem_wrap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_signed = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_done;
    logic        rsp_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    byte_mem_wrap dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_signed (req_signed),
        .req_wdata  (req_wdata),
        .rsp_rdata  (rsp_rdata),
        .rsp_done   (rsp_done),
        .rsp_err    (rsp_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [6:0] a, input logic [1:0] sz,
                          input logic sg, input logic [31:0] wd,
                          output logic [31:0] rd, output logic er, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_size = sz; req_signed = sg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic load_word(input logic [6:0] a, output logic [31:0] rd);
        logic e; int l;
        do_req(1'b0, a, 2'b10, 1'b0, 32'h0, rd, e, l);
    endtask

    task automatic t_reset;
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 done", 32'(rsp_done), 32'd0);
        chk("R1 err", 32'(rsp_err), 32'd0);
        chk("R1 rdata", rsp_rdata, 32'd0);
    endtask

    task automatic t_word;
        logic [31:0] rd; logic e; int l;
        do_req(1'b1, 7'h10, 2'b10, 1'b0, 32'h1234ABCD, rd, e, l);
        chk("R9 word store latency", 32'(l), 32'd1);
        chk("R11 rdata zero on store", rd, 32'd0);
        do_req(1'b0, 7'h10, 2'b10, 1'b1, 32'h0, rd, e, l);
        chk("R5 word load", rd, 32'h1234ABCD);
        chk("R9 load latency", 32'(l), 32'd1);
        @(negedge clk);
        chk("R11 done drops", 32'(rsp_done), 32'd0);
        do_req(1'b0, 7'h13, 2'b00, 1'b0, 32'h0, rd, e, l);
        chk("R2 same entry lane3", rd, 32'h00000012);
        do_req(1'b0, 7'h11, 2'b00, 1'b0, 32'h0, rd, e, l);
        chk("R2 same entry lane1", rd, 32'h000000AB);
    endtask

    task automatic t_byte_load;
        logic [31:0] rd; logic e; int l;
        do_req(1'b1, 7'h20, 2'b10, 1'b0, 32'h80FF7F01, rd, e, l);
        do_req(1'b0, 7'h20, 2'b00, 1'b1, 32'h0, rd, e, l);
        chk("R3 lane0 signed", rd, 32'h00000001);
        do_req(1'b0, 7'h21, 2'b00, 1'b1, 32'h0, rd, e, l);
        chk("R3 lane1 signed pos", rd, 32'h0000007F);
        do_req(1'b0, 7'h22, 2'b00, 1'b1, 32'h0, rd, e, l);
        chk("R3 lane2 signed neg", rd, 32'hFFFFFFFF);
        do_req(1'b0, 7'h23, 2'b00, 1'b1, 32'h0, rd, e, l);
        chk("R3 lane3 signed", rd, 32'hFFFFFF80);
        do_req(1'b0, 7'h23, 2'b00, 1'b0, 32'h0, rd, e, l);
        chk("R3 lane3 unsigned", rd, 32'h00000080);
    endtask

    task automatic t_half_load;
        logic [31:0] rd; logic e; int l;
        do_req(1'b0, 7'h20, 2'b01, 1'b1, 32'h0, rd, e, l);
        chk("R4 low half signed", rd, 32'h00007F01);
        do_req(1'b0, 7'h22, 2'b01, 1'b1, 32'h0, rd, e, l);
        chk("R4 high half signed", rd, 32'hFFFF80FF);
        do_req(1'b0, 7'h22, 2'b01, 1'b0, 32'h0, rd, e, l);
        chk("R4 high half unsigned", rd, 32'h000080FF);
    endtask

    task automatic t_byte_store;
        logic [31:0] rd; logic e; int l;
        do_req(1'b1, 7'h22, 2'b00, 1'b0, 32'hFFFFFFAA, rd, e, l);
        chk("R9 byte store latency", 32'(l), 32'd2);
        chk("R6 no err", 32'(e), 32'd0);
        load_word(7'h20, rd);
        chk("R6 byte lane merge", rd, 32'h80AA7F01);
        do_req(1'b1, 7'h20, 2'b00, 1'b0, 32'h00000055, rd, e, l);
        load_word(7'h20, rd);
        chk("R6 lane0 merge", rd, 32'h80AA7F55);
    endtask

    task automatic t_half_store;
        logic [31:0] rd; logic e; int l;
        do_req(1'b1, 7'h12, 2'b01, 1'b0, 32'hEEEE5566, rd, e, l);
        chk("R9 half store latency", 32'(l), 32'd2);
        load_word(7'h10, rd);
        chk("R7 high half merge", rd, 32'h5566ABCD);
        do_req(1'b1, 7'h10, 2'b01, 1'b0, 32'h00009988, rd, e, l);
        load_word(7'h10, rd);
        chk("R7 low half merge", rd, 32'h55669988);
    endtask

    task automatic t_fault;
        logic [31:0] rd; logic e; int l;
        do_req(1'b1, 7'h21, 2'b01, 1'b0, 32'h0000DEAD, rd, e, l);
        chk("R8 half misaligned err", 32'(e), 32'd1);
        chk("R9 fault latency", 32'(l), 32'd1);
        do_req(1'b1, 7'h22, 2'b10, 1'b0, 32'hDEADDEAD, rd, e, l);
        chk("R8 word misaligned err", 32'(e), 32'd1);
        do_req(1'b0, 7'h22, 2'b10, 1'b0, 32'h0, rd, e, l);
        chk("R8 misaligned load err", 32'(e), 32'd1);
        chk("R8 misaligned load rdata", rd, 32'd0);
        do_req(1'b1, 7'h20, 2'b11, 1'b0, 32'h0BADF00D, rd, e, l);
        chk("R8 reserved size err", 32'(e), 32'd1);
        load_word(7'h20, rd);
        chk("R8 memory unchanged", rd, 32'h80AA7F55);
    endtask

    task automatic t_busy;
        logic [31:0] rd; logic e; int l;
        do_req(1'b1, 7'h04, 2'b10, 1'b0, 32'h11223344, rd, e, l);
        do_req(1'b1, 7'h08, 2'b10, 1'b0, 32'hDEADBEEF, rd, e, l);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 7'h05;
        req_size = 2'b00; req_signed = 1'b0; req_wdata = 32'h000000C3;
        @(negedge clk);
        chk("R10 not ready in read step", 32'(req_ready), 32'd0);
        chk("R9 no done in read step", 32'(rsp_done), 32'd0);
        req_addr = 7'h08; req_size = 2'b10; req_wdata = 32'h000000FF;
        @(negedge clk);
        chk("R9 done in write step", 32'(rsp_done), 32'd1);
        chk("R10 not ready at done", 32'(req_ready), 32'd0);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 done single pulse", 32'(rsp_done), 32'd0);
        chk("R10 ready after", 32'(req_ready), 32'd1);
        load_word(7'h04, rd);
        chk("R10 registered fields used", rd, 32'h1122C344);
        load_word(7'h08, rd);
        chk("R10 late request ignored", rd, 32'hDEADBEEF);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word();
        t_byte_load();
        t_half_load();
        t_byte_store();
        t_half_store();
        t_fault();
        t_busy();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule